// File: doc/BRIEF.md
# Run-Time Remappable Core-to-Monitor Crossbar

This block sits between a cluster of processing cores and a larger pool of execution monitors. Each core emits a small hash for every instruction it executes, qualified by a valid strobe. Each monitor checks one such stream and answers with a reset/recovery signal. A supervising processor decides which monitor watches which core and can change this assignment while the cores run.

The crossbar keeps two views of the assignment. The first is a monitor-select field per core. The forward demultiplexer uses it to steer that core's hash to one monitor. The second is a processor-select field per monitor. The return demultiplexer uses it to send the monitor's reset/recovery bit back to its owner. One register stage sits on each direction.

A configuration write is checked at once. If it is accepted, it is parked as a pending change for that core. The change is committed only on a clock edge where the core reports itself idle, so a core never switches monitors in the middle of a stream. The hash stream has a valid strobe but no ready. There is no back-pressure on either side, and a monitor must accept a hash on every cycle its valid is high.

Top module: `core_monitor_xbar`

## Requirements
- R1: A hash and valid presented by a core that currently owns monitor m appear on monitor m's hash and valid outputs exactly one clock later.
- R2: A monitor owned by no core drives valid low and a hash of zero.
- R3: A core's reset/recovery output equals, one clock later, the reset/recovery input of the monitor that core owns. A core that owns no monitor sees 0.
- R4: An assign write (`cfg_en`=1) naming a monitor index of `NUM_MONS` or more is rejected. After that edge `cfg_err` reads 1, and no mapping or pending change is altered.
- R5: An assign write naming a monitor that another core holds, either active or as a pending assignment, is rejected with `cfg_err`=1. Two cores therefore never own one monitor.
- R6: An accepted write clears `cfg_err` and replaces any earlier pending change of the same core. It does not move routing by itself.
- R7: A pending change is committed on the first rising edge where that core's `core_idle` bit is 1. This may be the edge right after the write. Routing uses the new mapping from the next edge on. While idle stays 0, the old mapping stays in force.
- R8: A detach write (`cfg_en`=0, `cfg_mon` ignored) removes the core's monitor once it is committed. The freed monitor then falls under R2.
- R9: Under active-low reset, all mappings and pending changes are cleared, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_hash | input | NUM_CORES*HASH_W | Per-core instruction hash, core c at bits [c*HASH_W +: HASH_W] |
| core_valid | input | NUM_CORES | Per-core hash valid |
| core_idle | input | NUM_CORES | Per-core quiescent indication, permits commit of a pending change |
| core_rr | output | NUM_CORES | Per-core reset/recovery, routed back from its monitor |
| mon_hash | output | NUM_MONS*HASH_W | Per-monitor hash, monitor m at bits [m*HASH_W +: HASH_W] |
| mon_valid | output | NUM_MONS | Per-monitor hash valid |
| mon_rr | input | NUM_MONS | Per-monitor reset/recovery request |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | 1 = assign core to `cfg_mon`, 0 = detach core |
| cfg_core | input | CORE_SEL_W | Core addressed by the write |
| cfg_mon | input | MON_SEL_W | Monitor index for an assign |
| cfg_err | output | 1 | 1 when the most recent write was rejected, cleared by an accepted write |

## Verification
The forward and return paths each carry one register, so their outputs are due on the edge after the inputs are sampled. Both are compared with the mapping as it stood before that edge. `cfg_err` follows a write by one edge. A mapping change becomes visible on routing two edges after the write at the earliest: one edge parks it and a later idle edge commits it. The bench's reference model advances at each rising edge in that same order (route with the old mapping, commit, then accept the write). It compares every output at the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic [1:0] {
    WR_ACCEPT = 2'd0,
    WR_RANGE  = 2'd1,
    WR_CLASH  = 2'd2
  } wr_verdict_e;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/xbar_map_table.sv
module xbar_map_table
  import xbar_pkg::*;
#(
  parameter int NC = 4,
  parameter int NM = 6,
  parameter int MW = 3,
  parameter int CW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic                  cfg_en,
  input  logic [CW-1:0]         cfg_core,
  input  logic [MW-1:0]         cfg_mon,
  input  logic [NC-1:0]         core_idle,
  output logic [NC-1:0]         core_act,
  output logic [NC-1:0][MW-1:0] core_sel,
  output logic [NM-1:0]         mon_own,
  output logic [NM-1:0][CW-1:0] mon_psel,
  output logic                  cfg_err
);

  logic [NC-1:0]         act_q, pv_q, pen_q;
  logic [NC-1:0][MW-1:0] sel_q, pmon_q;
  logic [NM-1:0]         own_q;
  logic [NM-1:0][CW-1:0] psel_q;
  logic                  err_q;
  logic                  clash;
  wr_verdict_e           verdict;

  // check of an incoming write against the other cores' held monitors
  always_comb begin
    clash = 1'b0;
    for (int k = 0; k < NC; k++) begin
      if (CW'(k) != cfg_core) begin
        if (act_q[k] && sel_q[k] == cfg_mon) clash = 1'b1;
        if (pv_q[k] && pen_q[k] && pmon_q[k] == cfg_mon) clash = 1'b1;
      end
    end
    if (int'(cfg_core) >= NC)                 verdict = WR_RANGE;
    else if (!cfg_en)                         verdict = WR_ACCEPT;
    else if (int'(cfg_mon) >= NM)             verdict = WR_RANGE;
    else if (clash)                           verdict = WR_CLASH;
    else                                      verdict = WR_ACCEPT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      sel_q  <= '0;
      pv_q   <= '0;
      pen_q  <= '0;
      pmon_q <= '0;
      own_q  <= '0;
      psel_q <= '0;
      err_q  <= 1'b0;
    end else begin
      // commit pending changes of idle cores
      for (int c = 0; c < NC; c++) begin
        if (pv_q[c] && core_idle[c]) begin
          act_q[c] <= pen_q[c];
          sel_q[c] <= pen_q[c] ? pmon_q[c] : '0;
          pv_q[c]  <= 1'b0;
        end
      end
      // per-monitor view: release first, then claim
      for (int c = 0; c < NC; c++) begin
        if (pv_q[c] && core_idle[c] && act_q[c]) begin
          for (int m = 0; m < NM; m++)
            if (sel_q[c] == MW'(m)) own_q[m] <= 1'b0;
        end
      end
      for (int c = 0; c < NC; c++) begin
        if (pv_q[c] && core_idle[c] && pen_q[c]) begin
          for (int m = 0; m < NM; m++)
            if (pmon_q[c] == MW'(m)) begin
              own_q[m]  <= 1'b1;
              psel_q[m] <= CW'(c);
            end
        end
      end
      // a new write parks after any commit of the same edge
      if (cfg_wr) begin
        if (verdict == WR_ACCEPT) begin
          for (int c = 0; c < NC; c++) begin
            if (CW'(c) == cfg_core) begin
              pv_q[c]   <= 1'b1;
              pen_q[c]  <= cfg_en;
              pmon_q[c] <= cfg_mon;
            end
          end
          err_q <= 1'b0;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign core_act = act_q;
  assign core_sel = sel_q;
  assign mon_own  = own_q;
  assign mon_psel = psel_q;
  assign cfg_err  = err_q;

  // R4: out-of-range assign is flagged
  p_range_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_en && int'(cfg_mon) >= NM) |=> cfg_err);

  for (genvar gc = 0; gc < NC; gc++) begin : g_core_chk
    // R7: mapping only moves after an idle edge
    p_commit_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q[gc] != $past(act_q[gc]) || sel_q[gc] != $past(sel_q[gc]))
        |-> $past(core_idle[gc]));
    // R5: core view agrees with monitor view
    p_core_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[gc] |-> (own_q[sel_q[gc]] && psel_q[sel_q[gc]] == CW'(gc)));
  end

  for (genvar gm = 0; gm < NM; gm++) begin : g_mon_chk
    // R5: each owned monitor has exactly the owner recorded
    p_mon_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
      own_q[gm] |-> (act_q[psel_q[gm]] && sel_q[psel_q[gm]] == MW'(gm)));
  end

endmodule

// File: rtl/xbar_hash_route.sv
module xbar_hash_route #(
  parameter int NC = 4,
  parameter int NM = 6,
  parameter int HW = 4,
  parameter int MW = 3,
  parameter int CW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NC-1:0][HW-1:0] core_hash,
  input  logic [NC-1:0]         core_valid,
  input  logic [NC-1:0]         core_act,
  input  logic [NC-1:0][MW-1:0] core_sel,
  input  logic [NM-1:0]         mon_own,
  input  logic [NM-1:0][CW-1:0] mon_psel,
  output logic [NM-1:0][HW-1:0] mon_hash,
  output logic [NM-1:0]         mon_valid
);

  logic [NM-1:0][HW-1:0] hash_d;
  logic [NM-1:0]         valid_d;

  // per-core demultiplexer driven by the core's monitor-select field
  always_comb begin
    hash_d  = '0;
    valid_d = '0;
    for (int m = 0; m < NM; m++) begin
      for (int c = 0; c < NC; c++) begin
        if (core_act[c] && core_sel[c] == MW'(m)) begin
          hash_d[m]  = hash_d[m] | core_hash[c];
          valid_d[m] = valid_d[m] | core_valid[c];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_hash  <= '0;
      mon_valid <= '0;
    end else begin
      mon_hash  <= hash_d;
      mon_valid <= valid_d;
    end
  end

  for (genvar gm = 0; gm < NM; gm++) begin : g_chk
    // R2: an unowned monitor stays silent
    p_free_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_own[gm] |=> (!mon_valid[gm] && mon_hash[gm] == '0));
    // R1: owned monitor mirrors its owner's strobe one clock later
    p_fwd_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mon_own[gm] |=> (mon_valid[gm] == $past(core_valid[mon_psel[gm]])));
  end

endmodule

// File: rtl/xbar_rr_route.sv
module xbar_rr_route #(
  parameter int NC = 4,
  parameter int NM = 6,
  parameter int CW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NM-1:0]         mon_rr,
  input  logic [NM-1:0]         mon_own,
  input  logic [NM-1:0][CW-1:0] mon_psel,
  input  logic [NC-1:0]         core_act,
  output logic [NC-1:0]         core_rr
);

  logic [NC-1:0] rr_d;

  // per-monitor demultiplexer driven by the processor-select field
  always_comb begin
    rr_d = '0;
    for (int c = 0; c < NC; c++) begin
      for (int m = 0; m < NM; m++) begin
        if (mon_own[m] && mon_psel[m] == CW'(c)) rr_d[c] = rr_d[c] | mon_rr[m];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) core_rr <= '0;
    else        core_rr <= rr_d;
  end

  for (genvar gc = 0; gc < NC; gc++) begin : g_chk
    // R3: a core without a monitor never sees reset/recovery
    p_unmapped_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !core_act[gc] |=> !core_rr[gc]);
  end

endmodule

// File: rtl/core_monitor_xbar.sv
module core_monitor_xbar
  import xbar_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int NUM_MONS   = 6,
  parameter int HASH_W     = 4,
  parameter int CORE_SEL_W = sel_width(NUM_CORES),
  parameter int MON_SEL_W  = sel_width(NUM_MONS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CORES*HASH_W-1:0]  core_hash,
  input  logic [NUM_CORES-1:0]         core_valid,
  input  logic [NUM_CORES-1:0]         core_idle,
  output logic [NUM_CORES-1:0]         core_rr,
  output logic [NUM_MONS*HASH_W-1:0]   mon_hash,
  output logic [NUM_MONS-1:0]          mon_valid,
  input  logic [NUM_MONS-1:0]          mon_rr,
  input  logic                         cfg_wr,
  input  logic                         cfg_en,
  input  logic [CORE_SEL_W-1:0]        cfg_core,
  input  logic [MON_SEL_W-1:0]         cfg_mon,
  output logic                         cfg_err
);

  localparam int NC = NUM_CORES;
  localparam int NM = NUM_MONS;
  localparam int CW = CORE_SEL_W;
  localparam int MW = MON_SEL_W;

  logic [NC-1:0][HASH_W-1:0] hash_in;
  logic [NM-1:0][HASH_W-1:0] hash_out;
  logic [NC-1:0]             act;
  logic [NC-1:0][MW-1:0]     sel;
  logic [NM-1:0]             own;
  logic [NM-1:0][CW-1:0]     psel;

  for (genvar gc = 0; gc < NC; gc++) begin : g_in
    assign hash_in[gc] = core_hash[gc*HASH_W +: HASH_W];
  end
  for (genvar gm = 0; gm < NM; gm++) begin : g_out
    assign mon_hash[gm*HASH_W +: HASH_W] = hash_out[gm];
  end

  xbar_map_table #(.NC(NC), .NM(NM), .MW(MW), .CW(CW)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_en    (cfg_en),
    .cfg_core  (cfg_core),
    .cfg_mon   (cfg_mon),
    .core_idle (core_idle),
    .core_act  (act),
    .core_sel  (sel),
    .mon_own   (own),
    .mon_psel  (psel),
    .cfg_err   (cfg_err)
  );

  xbar_hash_route #(.NC(NC), .NM(NM), .HW(HASH_W), .MW(MW), .CW(CW)) u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_hash  (hash_in),
    .core_valid (core_valid),
    .core_act   (act),
    .core_sel   (sel),
    .mon_own    (own),
    .mon_psel   (psel),
    .mon_hash   (hash_out),
    .mon_valid  (mon_valid)
  );

  xbar_rr_route #(.NC(NC), .NM(NM), .CW(CW)) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .mon_rr   (mon_rr),
    .mon_own  (own),
    .mon_psel (psel),
    .core_act (act),
    .core_rr  (core_rr)
  );

endmodule

// File: tb/core_monitor_xbar_tb.sv
module core_monitor_xbar_tb;

  localparam int NC = 4;
  localparam int NM = 6;
  localparam int HW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC*HW-1:0] core_hash = '0;
  logic [NC-1:0]   core_valid = '0;
  logic [NC-1:0]   core_idle = '1;
  logic [NC-1:0]   core_rr;
  logic [NM*HW-1:0] mon_hash;
  logic [NM-1:0]   mon_valid;
  logic [NM-1:0]   mon_rr = '0;
  logic            cfg_wr = 1'b0;
  logic            cfg_en = 1'b0;
  logic [1:0]      cfg_core = '0;
  logic [2:0]      cfg_mon = '0;
  logic            cfg_err;

  always #4 clk = ~clk;

  core_monitor_xbar u_dut (
    .clk(clk), .rst_n(rst_n), .core_hash(core_hash), .core_valid(core_valid),
    .core_idle(core_idle), .core_rr(core_rr), .mon_hash(mon_hash),
    .mon_valid(mon_valid), .mon_rr(mon_rr), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_core(cfg_core), .cfg_mon(cfg_mon), .cfg_err(cfg_err)
  );

  // reference model state
  bit act[NC];
  int mapm[NC];
  bit pv[NC];
  bit pen[NC];
  int pm[NC];
  bit err_m;
  bit exp_mv[NM];
  int exp_mh[NM];
  bit exp_rr[NC];
  string err_tag = "R9";
  string ctx = "R9";
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        act[c] = 0; mapm[c] = 0; pv[c] = 0; pen[c] = 0; pm[c] = 0; exp_rr[c] = 0;
      end
      for (int m = 0; m < NM; m++) begin exp_mv[m] = 0; exp_mh[m] = 0; end
      err_m = 0;
    end else begin
      bit accept;
      string tag;
      for (int m = 0; m < NM; m++) begin
        exp_mv[m] = 0; exp_mh[m] = 0;
        for (int c = 0; c < NC; c++)
          if (act[c] && mapm[c] == m) begin
            exp_mv[m] = core_valid[c];
            exp_mh[m] = int'(core_hash[c*HW +: HW]);
          end
      end
      for (int c = 0; c < NC; c++) exp_rr[c] = act[c] ? mon_rr[mapm[c]] : 1'b0;
      accept = 1; tag = "R6";
      if (cfg_wr && cfg_en) begin
        if (int'(cfg_mon) >= NM) begin accept = 0; tag = "R4"; end
        else begin
          for (int k = 0; k < NC; k++)
            if (k != int'(cfg_core) &&
                ((act[k] && mapm[k] == int'(cfg_mon)) || (pv[k] && pen[k] && pm[k] == int'(cfg_mon)))) begin
              accept = 0; tag = "R5";
            end
        end
      end
      for (int c = 0; c < NC; c++)
        if (pv[c] && core_idle[c]) begin
          act[c] = pen[c]; mapm[c] = pen[c] ? pm[c] : 0; pv[c] = 0;
        end
      if (cfg_wr) begin
        err_tag = tag;
        if (accept) begin
          pv[cfg_core] = 1; pen[cfg_core] = cfg_en; pm[cfg_core] = int'(cfg_mon); err_m = 0;
        end else err_m = 1;
      end
    end
  end

  task automatic chk(input string req, input int act_v, input int exp_v, input string what);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s [%s] %s: actual=%0d expected=%0d at %0t", req, ctx, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int m = 0; m < NM; m++) begin
        bit owned = 0;
        for (int c = 0; c < NC; c++) if (act[c] && mapm[c] == m) owned = 1;
        chk(!rst_n ? "R9" : (owned ? "R1" : "R2"), int'(mon_valid[m]), int'(exp_mv[m]), $sformatf("mon_valid[%0d]", m));
        chk(!rst_n ? "R9" : (owned ? "R1" : "R2"), int'(mon_hash[m*HW +: HW]), exp_mh[m], $sformatf("mon_hash[%0d]", m));
      end
      for (int c = 0; c < NC; c++)
        chk(!rst_n ? "R9" : "R3", int'(core_rr[c]), int'(exp_rr[c]), $sformatf("core_rr[%0d]", c));
      chk(!rst_n ? "R9" : err_tag, int'(cfg_err), int'(err_m), "cfg_err");
    end
  end

  task automatic tick_rand();
    @(negedge clk); #1;
    core_hash  = NC*HW'($urandom);
    core_valid = NC'($urandom);
    mon_rr     = NM'($urandom);
    cfg_wr     = 1'b0;
  endtask

  task automatic wr(input bit en, input int core, input int mon);
    @(negedge clk); #1;
    core_hash  = NC*HW'($urandom);
    core_valid = NC'($urandom);
    mon_rr     = NM'($urandom);
    cfg_wr = 1'b1; cfg_en = en; cfg_core = 2'(core); cfg_mon = 3'(mon);
  endtask

  initial begin
    repeat (4) tick_rand();
    @(negedge clk); #1; rst_n = 1'b1;
    ctx = "R6";
    wr(1, 0, 0); wr(1, 1, 5); wr(1, 2, 3);
    repeat (3) tick_rand();
    ctx = "R5"; wr(1, 3, 0); tick_rand();
    ctx = "R4"; wr(1, 3, 7); tick_rand();
    ctx = "R6"; wr(1, 3, 1); repeat (3) tick_rand();
    ctx = "R7";
    @(negedge clk); #1; core_idle[0] = 1'b0;
    wr(1, 0, 2); repeat (6) tick_rand();
    @(negedge clk); #1; core_idle[0] = 1'b1;
    repeat (3) tick_rand();
    ctx = "R8"; wr(0, 1, 0); repeat (4) tick_rand();
    ctx = "R1";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      core_hash  = NC*HW'($urandom);
      core_valid = NC'($urandom);
      mon_rr     = NM'($urandom);
      core_idle  = NC'($urandom);
      cfg_wr     = ($urandom % 4) == 0;
      cfg_en     = ($urandom % 5) != 0;
      cfg_core   = 2'($urandom);
      cfg_mon    = 3'($urandom);
    end
    repeat (3) tick_rand();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule